// File: doc/BRIEF.md
# Synthesizer Tuning Word Loader

This block gathers the 40-bit programming word of a direct digital synthesizer and hands it to the synthesis core. The word holds a 32-bit frequency tuning value, a 5-bit phase offset, a power-down flag and a reference-multiplier enable. Software or a host controller writes it over an 8-bit port. In byte mode, up to five bytes go through an internal word pointer. In bit-stream mode, one bit is taken per write. Everything written lands in a staging register. The synthesis core keeps seeing the previous settings until an update strobe copies the staging register into the active register.

In byte mode the pointer always starts at word 0 and moves forward only. To change a later word, the earlier words must be written again. The host may issue the update strobe after any byte, so a partial load is valid. A word-0 byte with bit 1 set switches the loader into bit-stream mode, where it stays until reset.

All inputs are sampled on the rising edge of the write clock `clk`. The reset is synchronous and active low.

Top module: `dds_word_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointer, the bit counter, the mode, the staging register and the active outputs all return to zero. An update after reset with no writes therefore gives all-zero outputs.
- R2: In byte mode, the byte written at pointer position k (0 to 4) is staged as word k. Word 0 maps as follows: bits 7..3 are the phase, with bit 7 as its MSB; bit 2 is power-down; bit 0 is multiplier enable. Words 1 to 4 are the tuning word, most significant byte first, so word 1 holds bits 31..24 and word 4 holds bits 7..0.
- R3: The outputs change only at an edge where `upd_stb` is high. From the next cycle they show the staged fields as they stood before that edge.
- R4: An update after a partial load copies the newly written words and keeps the earlier staged contents of the words that were not rewritten.
- R5: An update returns the byte pointer to word 0, so the next byte written is word 0.
- R6: In byte mode, bytes written after word 4 and before an update have no effect.
- R7: A byte written as word 0 with bit 1 set is not staged. It switches the loader to bit-stream mode, with the bit counter at zero.
- R8: In bit-stream mode, each write shifts in `din[7]`. The first bit becomes tuning bit 0. Bit 32 becomes tuning bit 31. Bits 33, 35 and 36..40 become multiplier enable, power-down and phase bits 0..4.
- R9: In bit-stream mode, writes beyond the 40th since the last update or mode entry are discarded.
- R10: When `wr_stb` and `upd_stb` are high at the same edge, the write is dropped and only the update takes place.
- R11: Bit-stream mode stays in force until reset. The staged serial-select bit (the 34th bit shifted in) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_stb | input | 1 | Write qualifier for `din` |
| din | input | 8 | Byte data; bit 7 is the serial data bit |
| upd_stb | input | 1 | Update strobe: staging to active |
| tuning_word | output | 32 | Active frequency tuning word |
| phase_word | output | 5 | Active phase offset |
| pwr_down | output | 1 | Active power-down flag |
| mult_en | output | 1 | Active reference-multiplier enable |

## Verification
Random byte-mode bursts of one to seven bytes, each followed by an update, cover full loads, partial loads and overruns. Comparing them against a bench model separates correct pointer advance from wrong byte placement and from writes that spill past word 4. Directed cases cover these behaviours:
- holding the outputs when no update is given;
- a write coinciding with an update;
- a reset that occurs in the middle of a load.

In bit-stream mode, full 40-bit random patterns check the shift direction and the field mapping. Streams of 45 bits and streams shorter than 40 bits show whether extra bits are discarded and how partial shifts land.

// File: rtl/dds_ldr_pkg.sv
// Package: shared sizes for the tuning word loader.
// Assumes the word layout of phase/flags byte followed by four tuning bytes.
package dds_ldr_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NUM_WORDS = 5;
    localparam int unsigned TOTAL_W   = BYTE_W * NUM_WORDS;
    localparam int unsigned TUNE_W    = 32;
    localparam int unsigned PHASE_W   = 5;
    // bit positions inside the staged 40-bit vector
    localparam int unsigned POS_MULT  = TUNE_W;       // 32
    localparam int unsigned POS_SSEL  = TUNE_W + 1;   // 33
    localparam int unsigned POS_PD    = TUNE_W + 2;   // 34
    localparam int unsigned POS_PH_LO = TUNE_W + 3;   // 35
endpackage

// File: rtl/dds_par_path.sv
// Byte-mode sequencer: holds the forward-only word pointer and produces one
// byte enable per word. It also flags the serial-entry pattern on word 0.
// Assumes upd_stb has priority over wr_stb at the same edge.
module dds_par_path #(
    parameter int unsigned NUM_WORDS = 5,
    parameter int unsigned PTR_W     = $clog2(NUM_WORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic                 upd_stb,
    input  logic                 ser_mode,
    input  logic                 sel_bit,
    output logic [NUM_WORDS-1:0] byte_en,
    output logic                 enter_ser,
    output logic [PTR_W-1:0]     ptr
);
    logic wr_ok;
    logic ptr_at0;

    // Purpose: qualify a byte-mode write that is not overridden by an update.
    always_comb begin
        wr_ok   = wr_stb && !upd_stb && !ser_mode;
        ptr_at0 = (ptr == '0);
        enter_ser = wr_ok && ptr_at0 && sel_bit;
    end

    // Purpose: decode the pointer into per-word enables.
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_en
        if (k == 0) begin : g_w0
            assign byte_en[k] = wr_ok && ptr_at0 && !sel_bit;
        end else begin : g_wn
            assign byte_en[k] = wr_ok && (ptr == PTR_W'(k));
        end
    end

    // Purpose: advance the pointer on each accepted byte, clear on update.
    always_ff @(posedge clk) begin
        if (!rst_n)             ptr <= '0;
        else if (upd_stb)       ptr <= '0;
        else if (|byte_en)      ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/dds_ser_path.sv
// Bit-stream sequencer: holds the sticky serial mode flag and the bit counter.
// It allows a shift only while fewer than TOTAL_W bits have arrived.
// Assumes the mode is left only through reset.
module dds_ser_path #(
    parameter int unsigned TOTAL_W = 40,
    parameter int unsigned CNT_W   = $clog2(TOTAL_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             upd_stb,
    input  logic             enter_ser,
    output logic             ser_mode,
    output logic             shift_en,
    output logic [CNT_W-1:0] bit_cnt
);
    // Purpose: allow a shift for each write in serial mode until the word is full.
    always_comb begin
        shift_en = ser_mode && wr_stb && !upd_stb && (bit_cnt < CNT_W'(TOTAL_W));
    end

    // Purpose: make the mode flag sticky once the entry pattern is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)         ser_mode <= 1'b0;
        else if (enter_ser) ser_mode <= 1'b1;
    end

    // Purpose: count accepted serial bits, restart on update or mode entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                      bit_cnt <= '0;
        else if (upd_stb || enter_ser)   bit_cnt <= '0;
        else if (shift_en)               bit_cnt <= bit_cnt + 1'b1;
    end
endmodule

// File: rtl/dds_word_loader.sv
// Top: staging register fed by the byte or bit path, plus an active register
// loaded on update and presented to the synthesis core.
// Assumes a single write clock; all strobes are level-sampled at its edge.
module dds_word_loader
    import dds_ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] din,
    input  logic              upd_stb,
    output logic [TUNE_W-1:0] tuning_word,
    output logic [PHASE_W-1:0] phase_word,
    output logic              pwr_down,
    output logic              mult_en
);
    localparam int unsigned PTR_W = $clog2(NUM_WORDS + 1);
    localparam int unsigned CNT_W = $clog2(TOTAL_W + 1);

    logic [TOTAL_W-1:0]   stage_q;
    logic [TOTAL_W-1:0]   shifted;
    logic [NUM_WORDS-1:0] byte_en;
    logic                 enter_ser;
    logic                 ser_mode_w;
    logic                 shift_en;
    logic [PTR_W-1:0]     ptr_w;
    logic [CNT_W-1:0]     cnt_w;

    dds_par_path #(.NUM_WORDS(NUM_WORDS), .PTR_W(PTR_W)) u_par (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .upd_stb(upd_stb),
        .ser_mode(ser_mode_w), .sel_bit(din[1]),
        .byte_en(byte_en), .enter_ser(enter_ser), .ptr(ptr_w)
    );

    dds_ser_path #(.TOTAL_W(TOTAL_W), .CNT_W(CNT_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .upd_stb(upd_stb),
        .enter_ser(enter_ser), .ser_mode(ser_mode_w),
        .shift_en(shift_en), .bit_cnt(cnt_w)
    );

    // Purpose: the next staging value when one serial bit enters at the top.
    always_comb begin
        shifted = {din[BYTE_W-1], stage_q[TOTAL_W-1:1]};
    end

    // Purpose: per-word staging slices; word k sits most significant first.
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_stage
        localparam int unsigned LO = (NUM_WORDS - 1 - k) * BYTE_W;
        always_ff @(posedge clk) begin
            if (!rst_n)          stage_q[LO +: BYTE_W] <= '0;
            else if (byte_en[k]) stage_q[LO +: BYTE_W] <= din;
            else if (shift_en)   stage_q[LO +: BYTE_W] <= shifted[LO +: BYTE_W];
        end
    end

    // Purpose: copy staged fields to the active outputs on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tuning_word <= '0;
            phase_word  <= '0;
            pwr_down    <= 1'b0;
            mult_en     <= 1'b0;
        end else if (upd_stb) begin
            tuning_word <= stage_q[TUNE_W-1:0];
            phase_word  <= stage_q[POS_PH_LO +: PHASE_W];
            pwr_down    <= stage_q[POS_PD];
            mult_en     <= stage_q[POS_MULT];
        end
    end
endmodule

// File: rtl/dds_word_loader_chk.sv
// Checker: temporal properties of the loader, bound to the top module.
// Assumes it observes the staging vector, pointer, counter and mode.
module dds_word_loader_chk #(
    parameter int unsigned TOTAL_W = 40,
    parameter int unsigned PTR_W   = 3,
    parameter int unsigned CNT_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_stb,
    input logic [TOTAL_W-1:0] stage,
    input logic [31:0]        tuning_word,
    input logic [4:0]         phase_word,
    input logic               pwr_down,
    input logic               mult_en,
    input logic               ser_mode,
    input logic [PTR_W-1:0]   ptr,
    input logic [CNT_W-1:0]   bit_cnt
);
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (tuning_word == '0 && phase_word == '0 && !pwr_down && !mult_en
                    && ptr == '0 && bit_cnt == '0 && !ser_mode));

    p_hold_without_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_stb && rst_n) |=> ($stable(tuning_word) && $stable(phase_word)
                                 && $stable(pwr_down) && $stable(mult_en)));

    p_update_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && rst_n) |=> (tuning_word == $past(stage[31:0])
                                && phase_word == $past(stage[39:35])
                                && pwr_down == $past(stage[34])
                                && mult_en == $past(stage[32])));

    p_ptr_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> (ptr == '0));

    p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(5));

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(TOTAL_W));

    p_mode_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && rst_n) |=> ser_mode);
endmodule

bind dds_word_loader dds_word_loader_chk #(
    .TOTAL_W(40), .PTR_W(3), .CNT_W(6)
) chk_i (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .stage(stage_q),
    .tuning_word(tuning_word), .phase_word(phase_word),
    .pwr_down(pwr_down), .mult_en(mult_en),
    .ser_mode(ser_mode_w), .ptr(ptr_w), .bit_cnt(cnt_w)
);

// File: tb/dds_word_loader_tb.sv
// Bench: random byte bursts and directed serial cases against a bench model.
module dds_word_loader_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  din = '0;
    logic        upd_stb = 1'b0;
    logic [31:0] tuning_word;
    logic [4:0]  phase_word;
    logic        pwr_down;
    logic        mult_en;

    int total = 0;
    int bad = 0;

    // bench model state
    logic [39:0] m_stage = '0;
    logic [39:0] m_act = '0;
    int          m_ptr = 0;
    int          m_cnt = 0;
    bit          m_ser = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_word_loader dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .din(din), .upd_stb(upd_stb),
        .tuning_word(tuning_word), .phase_word(phase_word),
        .pwr_down(pwr_down), .mult_en(mult_en)
    );

    function automatic logic [38:0] exp_fields(logic [39:0] a);
        return {a[31:0], a[39:35], a[34], a[32]};
    endfunction

    task automatic m_write(logic [7:0] b);
        if (m_ser) begin
            if (m_cnt < 40) begin
                m_stage = {b[7], m_stage[39:1]};
                m_cnt++;
            end
        end else if (m_ptr == 0 && b[1]) begin
            m_ser = 1; m_cnt = 0;
        end else if (m_ptr < 5) begin
            m_stage[(4 - m_ptr) * 8 +: 8] = b;
            m_ptr++;
        end
    endtask

    task automatic m_upd();
        m_act = m_stage; m_ptr = 0; m_cnt = 0;
    endtask

    task automatic do_write(logic [7:0] b);
        @(negedge clk); wr_stb = 1'b1; din = b;
        @(negedge clk); wr_stb = 1'b0;
        m_write(b);
    endtask

    task automatic do_upd();
        @(negedge clk); upd_stb = 1'b1;
        @(negedge clk); upd_stb = 1'b0;
        m_upd();
    endtask

    task automatic do_both(logic [7:0] b);
        @(negedge clk); upd_stb = 1'b1; wr_stb = 1'b1; din = b;
        @(negedge clk); upd_stb = 1'b0; wr_stb = 1'b0;
        m_upd();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        m_stage = '0; m_act = '0; m_ptr = 0; m_cnt = 0; m_ser = 0;
    endtask

    task automatic check(string req);
        logic [38:0] got;
        got = {tuning_word, phase_word, pwr_down, mult_en};
        total++;
        if (got !== exp_fields(m_act)) begin
            bad++;
            $display("FAIL %s: got tw=%h ph=%h pd=%b me=%b exp tw=%h ph=%h pd=%b me=%b",
                     req, tuning_word, phase_word, pwr_down, mult_en,
                     m_act[31:0], m_act[39:35], m_act[34], m_act[32]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        check("R1 reset state");

        // R2: full directed load, known field mapping
        do_write(8'b1010_1101);          // phase=10101, pd=1, sel=0, mult=1
        do_write(8'h12); do_write(8'h34); do_write(8'h56); do_write(8'h78);
        check("R3 no update yet");
        do_upd();
        check("R2 full load mapping");
        if (tuning_word !== 32'h12345678 || phase_word !== 5'b10101 || !pwr_down || !mult_en) begin
            bad++;
            $display("FAIL R2: got tw=%h ph=%b exp tw=12345678 ph=10101", tuning_word, phase_word);
        end
        total++;

        // R4/R5: partial load of W0, W1 keeps W2..W4
        do_write(8'h08); do_write(8'hAB); do_upd();
        check("R4 partial load keeps later words");
        do_write(8'hF8); do_upd();
        check("R5 pointer back at W0");

        // R6: overrun bytes ignored
        for (int i = 0; i < 5; i++) do_write(8'h11 * (i + 1) & 8'hFD);
        do_write(8'hEE); do_write(8'h99); do_upd();
        check("R6 overrun ignored");

        // R10: write with update dropped
        do_write(8'h00); do_both(8'h70); do_upd();
        check("R10 same-edge write dropped");

        // random byte bursts
        for (int it = 0; it < 40; it++) begin
            int n;
            logic [7:0] b;
            n = 1 + ($urandom % 7);
            for (int j = 0; j < n; j++) begin
                b = 8'($urandom);
                if (j == 0) b[1] = 1'b0;
                do_write(b);
            end
            if ($urandom % 4 == 0) do_both(8'($urandom) & 8'hFD);
            else do_upd();
            check("R2 R4 R6 random burst");
        end

        // R1: reset mid-load clears staging
        do_write(8'hFD); do_write(8'hFF);
        do_reset();
        do_upd();
        check("R1 staging cleared by reset");

        // R7: enter serial mode; the entry byte is not staged
        do_write(8'hFA);
        do_upd();
        check("R7 entry byte not staged");

        // R8: full 40-bit serial loads
        for (int it = 0; it < 12; it++) begin
            logic [39:0] v;
            v = {8'($urandom), 32'($urandom)};
            for (int k = 0; k < 40; k++) do_write({v[k], 7'($urandom)});
            do_upd();
            check("R8 R11 serial 40-bit load");
        end

        // R9: 45 bits, the last five discarded
        begin
            logic [44:0] v;
            v = {13'($urandom), 32'($urandom)};
            for (int k = 0; k < 45; k++) do_write({v[k], 7'h00});
            do_upd();
            check("R9 extra bits discarded");
        end

        // R8: partial serial shift of 12 bits
        for (int k = 0; k < 12; k++) do_write({k[0], 7'h7F});
        do_upd();
        check("R8 partial serial shift");

        // R11: serial-select bit set in stream, mode stays serial
        for (int k = 0; k < 40; k++) do_write({(k == 33) ? 1'b1 : k[1], 7'h02});
        do_upd();
        check("R11 select bit no effect");
        do_write(8'h00); do_write(8'h80); do_upd();
        check("R11 still serial mode");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule